// File: doc/BRIEF.md
# CPU Control Register Unit

This unit keeps the two control registers that sequence an 8-bit microcontroller core. The first is a 16-bit program counter that points at the next instruction. The second is an 8-bit status word that holds the condition flags, the register-bank select bits, the in-service priority bit and the interrupt-enable bit. The decoder, the ALU, the stack memory and the interrupt arbiter sit outside the unit. The unit only takes their decoded strobes and applies them to its registers in a fixed order of priority.

After reset the unit does not run at once. It first reads a two-byte start address from memory through a request/response port. The request side follows valid/ready rules: a request that is raised stays up with the same address until the memory accepts it. The response side is accepted only while the unit shows it is ready for response data. Response beats offered at any other time are dropped, and no back-pressure reaches the memory from them. A busy output stays high until both bytes are in.

During execution the sequencer advances the counter by the length of each instruction, or loads a branch target into it. It also pulses strobes that enable interrupts, disable them, acknowledge an interrupt, write ALU flags, or restore the status word from the stack. The status word is always on an output, so the sequencer can stack the value it holds before an acknowledge takes effect.

Top module: `cpu_ctl_regs`

## Requirements
- R1: While reset is low, the unit shows pc = 0000h, psw = 02h and busy = 1.
- R2: After reset, the unit reads the start address. The byte returned for address 0000h becomes pc[7:0] and the byte for address 0001h becomes pc[15:8]. Each byte is visible on pc from the edge that accepts it. Busy falls on the same edge that accepts the high byte and never rises again until the next reset.
- R3: A request is valid only in its request phase. While vec_req_ready is low, vec_req_valid stays high and vec_req_addr does not change. The unit accepts a response only while vec_rsp_ready is high. That is the cycle after the request was accepted and every cycle until a response arrives. A response at any other time leaves pc unchanged.
- R4: While busy is 1, pc_adv and pc_load have no effect on pc.
- R5: When busy is 0 and pc_adv is 1 without pc_load, pc becomes pc + pc_adv_len (0 to 7) modulo 2^16 on the next edge.
- R6: When pc_load is 1 and busy is 0, pc becomes pc_target on the next edge, even if pc_adv is also 1.
- R7: ei_exec sets psw bit 7 (interrupt enable). di_exec or int_ack clears it. A clear wins over a set in the same cycle. int_en always equals psw bit 7.
- R8: The psw output carries the stored value in every cycle. In the cycle that int_ack is high it still shows bit 7 as it was before the acknowledge.
- R9: When psw_restore is 1, psw takes psw_restore_data on the next edge. This overrides flag writes and the EI, DI and acknowledge strobes in that cycle.
- R10: psw bit 2 always reads 0, even when a restore or a flag write supplies a 1 there.
- R11: A flag write sets each psw bit whose flag_wr_mask bit is 1 to the matching flag_wr_val bit, and leaves the other bits unchanged. The bit layout is 7 interrupt enable, 6 zero, 5 bank select high, 4 auxiliary carry, 3 bank select low, 2 fixed zero, 1 in-service priority, 0 carry. EI, DI and acknowledge act on bit 7 after the flag write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vec_req_valid | output | 1 | Start-address read request valid |
| vec_req_ready | input | 1 | Memory accepts the request |
| vec_req_addr | output | 16 | Address of the requested byte |
| vec_rsp_valid | input | 1 | Memory returns a byte |
| vec_rsp_ready | output | 1 | Unit waits for a response byte |
| vec_rsp_data | input | 8 | Returned byte |
| busy | output | 1 | Start-address fetch in progress |
| pc_adv | input | 1 | Advance pc by instruction length |
| pc_adv_len | input | 3 | Instruction length in bytes |
| pc_load | input | 1 | Load branch target |
| pc_target | input | 16 | Branch target |
| ei_exec | input | 1 | Enable-interrupts instruction |
| di_exec | input | 1 | Disable-interrupts instruction |
| int_ack | input | 1 | Interrupt acknowledged |
| flag_wr_mask | input | 8 | Per-bit status write enables from the ALU |
| flag_wr_val | input | 8 | Status bit values from the ALU |
| psw_restore | input | 1 | Reload status word from stack |
| psw_restore_data | input | 8 | Status word popped from stack |
| pc | output | 16 | Program counter |
| psw | output | 8 | Status word, also the value to stack |
| int_en | output | 1 | Interrupt-enable flag |

## Verification
Some behaviours are checked by assertions on every cycle. These are the request hold under back-pressure, the frozen counter while busy, the advance and branch arithmetic, the zero in bit 2, the direction bit 7 takes after each strobe combination, and restore winning over the other writes. Other behaviours need the bench's scenarios. These include the byte order of the start address over varied stall lengths, the drop of responses outside the wait phase, the reset values, and the value offered for stacking in the acknowledge cycle. The bench also sweeps every flag mask, every restore byte and every combination of the three enable strobes, including the mask-then-strobe ordering.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int PSW_W = 8;

  // status word bit positions
  localparam int PSW_IE   = 7;
  localparam int PSW_ZF   = 6;
  localparam int PSW_RB1  = 5;
  localparam int PSW_AC   = 4;
  localparam int PSW_RB0  = 3;
  localparam int PSW_ZERO = 2;
  localparam int PSW_ISP  = 1;
  localparam int PSW_CY   = 0;

  localparam logic [PSW_W-1:0] PSW_RESET  = 8'h02;
  localparam logic [PSW_W-1:0] PSW_KEEP   = ~(8'h01 << PSW_ZERO);

  typedef enum logic [2:0] {
    VF_REQ_LO,
    VF_WAIT_LO,
    VF_REQ_HI,
    VF_WAIT_HI,
    VF_RUN
  } vf_state_e;

endpackage

// File: rtl/vec_fetch.sv
module vec_fetch
  import ctlreg_pkg::*;
#(
  parameter int                ADDR_W   = 16,
  parameter int                DATA_W   = 8,
  parameter logic [ADDR_W-1:0] VEC_BASE = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  output logic              rsp_ready,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              lo_we,
  output logic              hi_we,
  output logic [DATA_W-1:0] byte_out,
  output logic              busy
);

  localparam logic [ADDR_W-1:0] HI_OFS = ADDR_W'(1);

  vf_state_e state, state_nx;

  always_comb begin
    state_nx = state;
    case (state)
      VF_REQ_LO:  if (req_ready) state_nx = VF_WAIT_LO;
      VF_WAIT_LO: if (rsp_valid) state_nx = VF_REQ_HI;
      VF_REQ_HI:  if (req_ready) state_nx = VF_WAIT_HI;
      VF_WAIT_HI: if (rsp_valid) state_nx = VF_RUN;
      default:    state_nx = VF_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= VF_REQ_LO;
    else        state <= state_nx;
  end

  assign req_valid = (state == VF_REQ_LO) || (state == VF_REQ_HI);
  assign req_addr  = (state == VF_REQ_HI) ? VEC_BASE + HI_OFS : VEC_BASE;
  assign rsp_ready = (state == VF_WAIT_LO) || (state == VF_WAIT_HI);
  assign lo_we     = (state == VF_WAIT_LO) && rsp_valid;
  assign hi_we     = (state == VF_WAIT_HI) && rsp_valid;
  assign byte_out  = rsp_data;
  assign busy      = (state != VF_RUN);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr)); // R3

  AST_BUSY_STAYS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy); // R2

  AST_NO_RSP_IN_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !($onehot0({req_valid, rsp_ready}) == 1'b0)); // R3

endmodule

// File: rtl/pc_reg.sv
module pc_reg #(
  parameter int PC_W   = 16,
  parameter int DATA_W = 8,
  parameter int LEN_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              lo_we,
  input  logic              hi_we,
  input  logic [DATA_W-1:0] vec_byte,
  input  logic              adv,
  input  logic [LEN_W-1:0]  adv_len,
  input  logic              load,
  input  logic [PC_W-1:0]   target,
  output logic [PC_W-1:0]   pc
);

  localparam int PAD_W = PC_W - LEN_W;
  localparam int HI_W  = PC_W - DATA_W;

  logic [PC_W-1:0] step;
  logic [PC_W-1:0] pc_nx;

  assign step = {{PAD_W{1'b0}}, adv_len};

  always_comb begin
    pc_nx = pc;
    if (busy) begin
      if (lo_we) pc_nx[DATA_W-1:0] = vec_byte;
      if (hi_we) pc_nx[PC_W-1:DATA_W] = vec_byte[HI_W-1:0];
    end else if (load) begin
      pc_nx = target;
    end else if (adv) begin
      pc_nx = pc + step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc <= '0;
    else        pc <= pc_nx;
  end

  AST_PC_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !lo_we && !hi_we |=> $stable(pc)); // R4

  AST_PC_BRANCH: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && load |=> pc == $past(target)); // R6

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && adv && !load |=> pc == $past(pc) + $past(step)); // R5

endmodule

// File: rtl/psw_reg.sv
module psw_reg
  import ctlreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ei,
  input  logic             di,
  input  logic             ack,
  input  logic [PSW_W-1:0] wr_mask,
  input  logic [PSW_W-1:0] wr_val,
  input  logic             restore,
  input  logic [PSW_W-1:0] restore_data,
  output logic [PSW_W-1:0] psw
);

  logic [PSW_W-1:0] flags_nx;
  logic [PSW_W-1:0] psw_nx;

  always_comb begin
    flags_nx = (psw & ~wr_mask) | (wr_val & wr_mask);
    if (ei)        flags_nx[PSW_IE] = 1'b1;
    if (di || ack) flags_nx[PSW_IE] = 1'b0;
    psw_nx = restore ? restore_data : flags_nx;
    psw_nx = psw_nx & PSW_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) psw <= PSW_RESET;
    else        psw <= psw_nx;
  end

  AST_BIT2_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !psw[PSW_ZERO]); // R10

  AST_IE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (di || ack) && !restore |=> !psw[PSW_IE]); // R7

  AST_IE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ei && !di && !ack && !restore |=> psw[PSW_IE]); // R7

  AST_RESTORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    restore |=> psw == ($past(restore_data) & PSW_KEEP)); // R9

endmodule

// File: rtl/cpu_ctl_regs.sv
module cpu_ctl_regs
  import ctlreg_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int LEN_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              vec_req_valid,
  input  logic              vec_req_ready,
  output logic [PC_W-1:0]   vec_req_addr,
  input  logic              vec_rsp_valid,
  output logic              vec_rsp_ready,
  input  logic [7:0]        vec_rsp_data,
  output logic              busy,
  input  logic              pc_adv,
  input  logic [LEN_W-1:0]  pc_adv_len,
  input  logic              pc_load,
  input  logic [PC_W-1:0]   pc_target,
  input  logic              ei_exec,
  input  logic              di_exec,
  input  logic              int_ack,
  input  logic [PSW_W-1:0]  flag_wr_mask,
  input  logic [PSW_W-1:0]  flag_wr_val,
  input  logic              psw_restore,
  input  logic [PSW_W-1:0]  psw_restore_data,
  output logic [PC_W-1:0]   pc,
  output logic [PSW_W-1:0]  psw,
  output logic              int_en
);

  localparam int BYTE_W = 8;

  logic              lo_we;
  logic              hi_we;
  logic [BYTE_W-1:0] vec_byte;

  vec_fetch #(
    .ADDR_W   (PC_W),
    .DATA_W   (BYTE_W),
    .VEC_BASE ('0)
  ) u_fetch (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (vec_req_valid),
    .req_ready (vec_req_ready),
    .req_addr  (vec_req_addr),
    .rsp_valid (vec_rsp_valid),
    .rsp_ready (vec_rsp_ready),
    .rsp_data  (vec_rsp_data),
    .lo_we     (lo_we),
    .hi_we     (hi_we),
    .byte_out  (vec_byte),
    .busy      (busy)
  );

  pc_reg #(
    .PC_W   (PC_W),
    .DATA_W (BYTE_W),
    .LEN_W  (LEN_W)
  ) u_pc (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .lo_we    (lo_we),
    .hi_we    (hi_we),
    .vec_byte (vec_byte),
    .adv      (pc_adv),
    .adv_len  (pc_adv_len),
    .load     (pc_load),
    .target   (pc_target),
    .pc       (pc)
  );

  psw_reg u_psw (
    .clk          (clk),
    .rst_n        (rst_n),
    .ei           (ei_exec),
    .di           (di_exec),
    .ack          (int_ack),
    .wr_mask      (flag_wr_mask),
    .wr_val       (flag_wr_val),
    .restore      (psw_restore),
    .restore_data (psw_restore_data),
    .psw          (psw)
  );

  assign int_en = psw[PSW_IE];

  AST_ACK_SAVE_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    int_ack && !psw_restore && int_en |=> $fell(int_en)); // R8

endmodule

// File: tb/tb_cpu_ctl_regs.sv
module tb_cpu_ctl_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vec_req_valid, vec_req_ready, vec_rsp_valid, vec_rsp_ready, busy;
  logic [15:0] vec_req_addr;
  logic [7:0]  vec_rsp_data;
  logic        pc_adv, pc_load, ei_exec, di_exec, int_ack, psw_restore;
  logic [2:0]  pc_adv_len;
  logic [15:0] pc_target, pc;
  logic [7:0]  flag_wr_mask, flag_wr_val, psw_restore_data, psw;
  logic        int_en;

  int tests = 0;
  int failed = 0;
  bit done = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  cpu_ctl_regs dut (
    .clk(clk), .rst_n(rst_n),
    .vec_req_valid(vec_req_valid), .vec_req_ready(vec_req_ready),
    .vec_req_addr(vec_req_addr), .vec_rsp_valid(vec_rsp_valid),
    .vec_rsp_ready(vec_rsp_ready), .vec_rsp_data(vec_rsp_data),
    .busy(busy), .pc_adv(pc_adv), .pc_adv_len(pc_adv_len),
    .pc_load(pc_load), .pc_target(pc_target), .ei_exec(ei_exec),
    .di_exec(di_exec), .int_ack(int_ack), .flag_wr_mask(flag_wr_mask),
    .flag_wr_val(flag_wr_val), .psw_restore(psw_restore),
    .psw_restore_data(psw_restore_data), .pc(pc), .psw(psw), .int_en(int_en)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle();
    vec_req_ready = 1'b0; vec_rsp_valid = 1'b0; vec_rsp_data = 8'h00;
    pc_adv = 1'b0; pc_adv_len = 3'd0; pc_load = 1'b0; pc_target = 16'h0;
    ei_exec = 1'b0; di_exec = 1'b0; int_ack = 1'b0;
    flag_wr_mask = 8'h00; flag_wr_val = 8'h00;
    psw_restore = 1'b0; psw_restore_data = 8'h00;
  endtask

  // one vector byte: stall, handshake, respond
  task automatic fetch_byte(input logic [15:0] addr, input int stall,
                            input logic [7:0] b, input logic [15:0] pc_before);
    for (int i = 0; i < stall; i++) begin
      vec_req_ready = 1'b0;
      vec_rsp_valid = 1'b1; vec_rsp_data = 8'hA5;      // stray response
      chk("R3 req held", {vec_req_valid, vec_rsp_ready, vec_req_addr}, {2'b10, addr});
      @(negedge clk);
      chk("R3 stray rsp ignored", pc, pc_before);
    end
    vec_rsp_valid = 1'b0;
    vec_req_ready = 1'b1;
    chk("R3 req addr", {vec_req_valid, vec_req_addr}, {1'b1, addr});
    @(negedge clk);
    vec_req_ready = 1'b0;
    chk("R3 rsp ready", {vec_req_valid, vec_rsp_ready}, 2'b01);
    vec_rsp_valid = 1'b1; vec_rsp_data = b;
    @(negedge clk);
    vec_rsp_valid = 1'b0;
  endtask

  task automatic boot(input logic [15:0] vec, input int stall);
    idle();
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset pc", pc, 16'h0000);
    chk("R1 reset psw", psw, 8'h02);
    chk("R1 reset busy", busy, 1'b1);
    rst_n = 1'b1;
    pc_load = 1'b1; pc_target = 16'hBEEF; pc_adv = 1'b1; pc_adv_len = 3'd5;
    fetch_byte(16'h0000, stall, vec[7:0], 16'h0000);
    chk("R2 low byte", pc, {8'h00, vec[7:0]});
    chk("R4 busy during fetch", busy, 1'b1);
    fetch_byte(16'h0001, stall + 1, vec[15:8], {8'h00, vec[7:0]});
    pc_load = 1'b0; pc_adv = 1'b0;
    chk("R2 full vector", pc, vec);
    chk("R2 busy low", busy, 1'b0);
    @(negedge clk);
    chk("R2 busy stays low", {busy, pc}, {1'b0, vec});
  endtask

  logic [7:0] exp_psw;

  function automatic logic [7:0] psw_next(input logic [7:0] cur, input logic [7:0] m,
      input logic [7:0] v, input logic e, input logic d, input logic a,
      input logic r, input logic [7:0] rd);
    logic [7:0] n;
    n = (cur & ~m) | (v & m);
    if (e) n[7] = 1'b1;
    if (d || a) n[7] = 1'b0;
    if (r) n = rd;
    n[2] = 1'b0;
    return n;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; failed++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    idle();
    @(negedge clk);
    boot(16'h1234, 0);
    boot(16'hFF00, 2);
    boot(16'h00FF, 4);
    boot(16'hA55A, 1);

    // R5 / R6: counter arithmetic sweep
    begin
      logic [15:0] bases [4];
      bases[0] = 16'h0000; bases[1] = 16'h1234; bases[2] = 16'hFFFC; bases[3] = 16'h7FFF;
      for (int b = 0; b < 4; b++) begin
        for (int l = 0; l < 8; l++) begin
          pc_load = 1'b1; pc_target = bases[b];
          @(negedge clk);
          pc_load = 1'b0;
          chk("R6 branch load", pc, bases[b]);
          pc_adv = 1'b1; pc_adv_len = 3'(l);
          @(negedge clk);
          pc_adv = 1'b0;
          chk("R5 advance", pc, 16'(bases[b] + 16'(l)));
        end
      end
      pc_load = 1'b1; pc_target = 16'h4321; pc_adv = 1'b1; pc_adv_len = 3'd3;
      @(negedge clk);
      chk("R6 load beats advance", pc, 16'h4321);
      pc_load = 1'b0; pc_adv = 1'b0;
    end

    // R11 / R10: every flag mask
    exp_psw = psw;
    for (int m = 0; m < 256; m++) begin
      flag_wr_mask = 8'(m);
      flag_wr_val  = 8'(m * 37 + 11);
      exp_psw = psw_next(exp_psw, flag_wr_mask, flag_wr_val, 1'b0, 1'b0, 1'b0, 1'b0, 8'h00);
      @(negedge clk);
      chk("R11 R10 flag write", psw, exp_psw);
    end
    flag_wr_mask = 8'h00;

    // R7 / R8: every EI/DI/ack combination from both IE states, with flag mask on bit 7
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 16; c++) begin
        psw_restore = 1'b1; psw_restore_data = s[0] ? 8'h80 : 8'h7B;
        @(negedge clk);
        psw_restore = 1'b0;
        exp_psw = (s[0] ? 8'h80 : 8'h7B) & 8'hFB;
        ei_exec = c[0]; di_exec = c[1]; int_ack = c[2];
        flag_wr_mask = c[3] ? 8'h80 : 8'h00; flag_wr_val = s[0] ? 8'h00 : 8'h80;
        chk("R8 stack value before edge", psw, exp_psw);
        exp_psw = psw_next(exp_psw, flag_wr_mask, flag_wr_val, ei_exec, di_exec, int_ack, 1'b0, 8'h00);
        @(negedge clk);
        ei_exec = 1'b0; di_exec = 1'b0; int_ack = 1'b0; flag_wr_mask = 8'h00;
        chk("R7 IE strobes", psw, exp_psw);
        chk("R7 int_en mirrors bit 7", int_en, exp_psw[7]);
      end
    end

    // R9 / R10: every restore byte against competing writes
    for (int r = 0; r < 256; r++) begin
      psw_restore = 1'b1; psw_restore_data = 8'(r);
      flag_wr_mask = 8'hFF; flag_wr_val = ~8'(r);
      ei_exec = r[0]; di_exec = r[1]; int_ack = r[2];
      @(negedge clk);
      chk("R9 R10 restore wins", psw, 8'(r) & 8'hFB);
    end
    idle();
    @(negedge clk);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule